// File: doc/BRIEF.md
# Bus Transfer Pattern Tester

This block exercises an n-bit register or bus path with the shortest pattern set that exposes every stuck bit and every short between two bits. A start pulse makes it push the patterns one per cycle onto a write port. Each returned word arrives on a read port one cycle after its write, and the block compares it with the word that was sent.

The first log2(n) patterns are halving patterns. In the first of them the upper half of the word is ones and the lower half is zeros. Each later halving pattern splits every run of equal bits in two. After these, any two bit positions have held different values at least once. The top and bottom bits never change across the halving patterns, so a closing pattern, the inverse of the first, gives every bit its other value. All patterns come from an index decode. No table of patterns is stored.

When the run ends, the block raises a done flag and a pass flag. It also reports the index of the first pattern that miscompared and the XOR mask of that miscompare. The result stays valid until the next run is accepted.

Top module: `bus_transfer_tester`

## Requirements
- R1: After reset, wr_valid_o, done_o and pass_o are 0, and first_fail_o and fail_mask_o are 0.
- R2: When start_i is sampled high at a clock edge while no run is in progress, wr_valid_o is 1 for exactly log2(WIDTH)+1 consecutive cycles, starting in the cycle after that edge. Pattern index 0 is written first and the indices ascend. wr_valid_o is 0 while done_o is 1.
- R3: Pattern k, for k from 0 to log2(WIDTH)-1, has bit i equal to bit (log2(WIDTH)-1-k) of the number i. For WIDTH=8 the patterns are 0xF0, 0xCC and 0xAA.
- R4: The last pattern, index log2(WIDTH), is the bitwise inverse of pattern 0. For WIDTH=8 it is 0x0F.
- R5: The word on rd_data_i in the cycle after a write is the reply to that write. It is compared with the pattern of that write.
- R6: done_o rises log2(WIDTH)+2 clock edges after the edge that accepted start_i. It stays 1 until the next accepted start, which clears it at that edge.
- R7: If every reply matched, pass_o is 1 while done_o is 1, and first_fail_o and fail_mask_o are 0. pass_o is 0 while done_o is 0.
- R8: On the first miscompare of a run, first_fail_o takes that pattern's index and fail_mask_o takes expected XOR observed. Later miscompares change neither value, and all patterns are still written.
- R9: A start_i pulse during a run has no effect on the write sequence, the done timing or the result.
- R10: Any single bit stuck at 0 or at 1 gives pass_o = 0. So does any pair of bits shorted together so that both read the AND of the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when no run is in progress |
| wr_valid_o | output | 1 | Pattern write strobe |
| wr_data_o | output | WIDTH | Pattern word, 0 when wr_valid_o is low |
| rd_data_i | input | WIDTH | Word returned by the path, one cycle after its write |
| done_o | output | 1 | Run finished, held until the next accepted start |
| pass_o | output | 1 | Every reply matched, valid with done_o |
| first_fail_o | output | $clog2(log2(WIDTH)+1) | Index of the first miscompared pattern |
| fail_mask_o | output | WIDTH | Expected XOR observed, for the first miscompare |

## Verification
Call the edge that accepts start_i E0. The writes appear after E0 through E(P-1), where P is the pattern count, and each reply is judged at the following edge. done_o and the result therefore settle after edge E(P+1). The bench drives start_i at a falling edge and then reads the outputs at every later falling edge. It expects wr_valid_o on exactly the first P of those reads and done_o first on read P+1. A scoreboard queue holds the expected pattern words and is checked against each strobed write as it occurs. The expected result is computed by passing the same words through a model of the faulty path.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_DRAIN
  } bt_state_e;
endpackage

// File: rtl/bt_pattern_gen.sv
module bt_pattern_gen #(
  parameter int unsigned WIDTH   = 8,
  parameter int unsigned NUM_PAT = $clog2(WIDTH) + 1,
  parameter int unsigned IDX_W   = $clog2(NUM_PAT)
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [WIDTH-1:0] pattern_o
);
  localparam int unsigned LOG2 = NUM_PAT - 1;

  logic [NUM_PAT-1:0][WIDTH-1:0] tbl;

  for (genvar k = 0; k < LOG2; k++) begin : g_halve
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      localparam int unsigned BIT_V = (i >> (LOG2 - 1 - k)) & 1;
      assign tbl[k][i] = (BIT_V != 0);
    end
  end

  // closing pattern: lower half ones
  for (genvar i = 0; i < WIDTH; i++) begin : g_final
    assign tbl[LOG2][i] = (i < WIDTH / 2);
  end

  always_comb begin
    pattern_o = '0;
    for (int k = 0; k < NUM_PAT; k++) begin
      if (int'(idx_i) == k) pattern_o = tbl[k];
    end
  end
endmodule

// File: rtl/bt_sequencer.sv
module bt_sequencer
  import bt_pkg::*;
#(
  parameter int unsigned NUM_PAT = 4,
  parameter int unsigned IDX_W   = $clog2(NUM_PAT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             accept_o,
  output logic             wr_valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_PAT - 1);

  bt_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;

  assign accept_o   = start_i && (state_q == ST_IDLE);
  assign wr_valid_o = (state_q == ST_WRITE);
  assign idx_o      = idx_q;
  assign done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_WRITE;
          idx_q   <= '0;
          done_q  <= 1'b0;
        end
        ST_WRITE: if (idx_q == LAST) state_q <= ST_DRAIN;
                  else idx_q <= idx_q + 1'b1;
        ST_DRAIN: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_quiet_when_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !wr_valid_o);

  assert_done_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  assert_run_not_restarted_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WRITE && idx_q != LAST) |=>
      (state_q == ST_WRITE && idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/bt_result_tracker.sv
module bt_result_tracker #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             wr_valid_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [WIDTH-1:0] rd_data_i,
  output logic             fail_seen_o,
  output logic [IDX_W-1:0] fail_idx_o,
  output logic [WIDTH-1:0] fail_mask_o
);
  logic             cmp_valid_q;
  logic [WIDTH-1:0] exp_q;
  logic [IDX_W-1:0] cmp_idx_q;
  logic             fail_seen_q;
  logic [IDX_W-1:0] fail_idx_q;
  logic [WIDTH-1:0] fail_mask_q;
  logic [WIDTH-1:0] diff;

  assign diff = exp_q ^ rd_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_valid_q <= 1'b0;
      exp_q       <= '0;
      cmp_idx_q   <= '0;
      fail_seen_q <= 1'b0;
      fail_idx_q  <= '0;
      fail_mask_q <= '0;
    end else if (clear_i) begin
      cmp_valid_q <= 1'b0;
      fail_seen_q <= 1'b0;
      fail_idx_q  <= '0;
      fail_mask_q <= '0;
    end else begin
      cmp_valid_q <= wr_valid_i;
      if (wr_valid_i) begin
        exp_q     <= wr_data_i;
        cmp_idx_q <= wr_idx_i;
      end
      if (cmp_valid_q && diff != '0 && !fail_seen_q) begin
        fail_seen_q <= 1'b1;
        fail_idx_q  <= cmp_idx_q;
        fail_mask_q <= diff;
      end
    end
  end

  assign fail_seen_o = fail_seen_q;
  assign fail_idx_o  = fail_idx_q;
  assign fail_mask_o = fail_mask_q;

  assert_first_fail_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_seen_q && !clear_i) |=> ($stable(fail_idx_q) && $stable(fail_mask_q)));
endmodule

// File: rtl/bus_transfer_tester.sv
module bus_transfer_tester #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned NUM_PAT = $clog2(WIDTH) + 1,
  localparam int unsigned IDX_W   = $clog2(NUM_PAT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             wr_valid_o,
  output logic [WIDTH-1:0] wr_data_o,
  input  logic [WIDTH-1:0] rd_data_i,
  output logic             done_o,
  output logic             pass_o,
  output logic [IDX_W-1:0] first_fail_o,
  output logic [WIDTH-1:0] fail_mask_o
);
  logic             accept;
  logic             wr_valid;
  logic [IDX_W-1:0] idx;
  logic [WIDTH-1:0] pattern;
  logic             fail_seen;

  bt_sequencer #(.NUM_PAT(NUM_PAT), .IDX_W(IDX_W)) i_seq (
    .clk_i, .rst_ni, .start_i,
    .accept_o  (accept),
    .wr_valid_o(wr_valid),
    .idx_o     (idx),
    .done_o    (done_o)
  );

  bt_pattern_gen #(.WIDTH(WIDTH), .NUM_PAT(NUM_PAT), .IDX_W(IDX_W)) i_gen (
    .idx_i    (idx),
    .pattern_o(pattern)
  );

  bt_result_tracker #(.WIDTH(WIDTH), .IDX_W(IDX_W)) i_trk (
    .clk_i, .rst_ni,
    .clear_i    (accept),
    .wr_valid_i (wr_valid),
    .wr_data_i  (wr_data_o),
    .wr_idx_i   (idx),
    .rd_data_i,
    .fail_seen_o(fail_seen),
    .fail_idx_o (first_fail_o),
    .fail_mask_o(fail_mask_o)
  );

  assign wr_valid_o = wr_valid;
  assign wr_data_o  = wr_valid ? pattern : '0;
  assign pass_o     = done_o && !fail_seen;

  assert_pass_clean_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> (fail_mask_o == '0 && first_fail_o == '0));
endmodule

// File: tb/test_bus_transfer_tester.sv
module test_bus_transfer_tester;
  localparam int W = 8;
  localparam int L = $clog2(W);
  localparam int P = L + 1;
  localparam int IW = $clog2(P);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          wr_valid;
  logic [W-1:0]  wr_data;
  logic [W-1:0]  rd_data;
  logic          done;
  logic          pass;
  logic [IW-1:0] first_fail;
  logic [W-1:0]  fail_mask;

  int n_chk = 0;
  int n_bad = 0;

  // path fault model
  logic [W-1:0] s0_m = '0, s1_m = '0;
  int br_a = -1, br_b = -1;
  logic [W-1:0] path_q;

  logic [W-1:0] exp_q[$];

  always #4 clk = ~clk;

  bus_transfer_tester #(.WIDTH(W)) i_bus_transfer_tester (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .wr_valid_o(wr_valid), .wr_data_o(wr_data), .rd_data_i(rd_data),
    .done_o(done), .pass_o(pass), .first_fail_o(first_fail), .fail_mask_o(fail_mask)
  );

  function automatic logic [W-1:0] path_fn(input logic [W-1:0] v);
    logic [W-1:0] r;
    logic a;
    r = (v & ~s0_m) | s1_m;
    if (br_a >= 0) begin
      a = r[br_a] & r[br_b];
      r[br_a] = a;
      r[br_b] = a;
    end
    return r;
  endfunction

  function automatic logic [W-1:0] pat_fn(input int k);
    logic [W-1:0] p;
    for (int i = 0; i < W; i++)
      p[i] = (k < L) ? (((i >> (L - 1 - k)) & 1) != 0) : (i < W / 2);
    return p;
  endfunction

  always_ff @(posedge clk) if (wr_valid) path_q <= wr_data;
  assign rd_data = path_fn(path_q);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // monitor: pop scoreboard on every strobed write (R2 R3 R4)
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R2 extra write", 32'(wr_data), 0);
      else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        check(wr_data == e, "R3/R4 pattern", 32'(wr_data), 32'(e));
      end
    end
  end

  task automatic run(input int extra_start);
    bit exp_pass = 1'b1;
    logic [IW-1:0] exp_idx = '0;
    logic [W-1:0] exp_mask = '0;
    for (int k = 0; k < P; k++) begin
      logic [W-1:0] p, o;
      p = pat_fn(k);
      exp_q.push_back(p);
      o = path_fn(p);
      if (exp_pass && o != p) begin
        exp_pass = 1'b0;
        exp_idx = IW'(k);
        exp_mask = o ^ p;
      end
    end
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    for (int c = 0; c <= P + 1; c++) begin
      @(negedge clk);
      start = (c == extra_start);
      check(wr_valid == (c < P), "R2 write window", 32'(wr_valid), 32'(c < P));
      check(done == (c == P + 1), "R6 done timing", 32'(done), 32'(c == P + 1));
      if (c <= P) @(posedge clk);
    end
    start = 1'b0;
    check(exp_q.size() == 0, "R2 all patterns written", exp_q.size(), 0);
    check(pass == exp_pass, "R7/R10 pass", 32'(pass), 32'(exp_pass));
    check(first_fail == exp_idx, "R8 first index", 32'(first_fail), 32'(exp_idx));
    check(fail_mask == exp_mask, "R8 mask", 32'(fail_mask), 32'(exp_mask));
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #3;
    check(!wr_valid && !done && !pass && first_fail == 0 && fail_mask == 0, "R1 reset", 0, 0);
    #20 rst_n = 1'b1;
    @(negedge clk);
    check(!wr_valid && !done && !pass, "R1 after release", 32'(done), 0);
    check(!pass, "R7 pass low before done", 32'(pass), 0);

    run(-1);                      // clean path: R5 R7
    repeat (5) @(negedge clk);
    check(done && pass, "R6 done held", 32'(done), 1);

    s1_m = 8'h80; run(-1);        // only closing pattern fails: R4 R8, idx 3 mask 80
    s1_m = '0;
    s0_m = 8'h80; run(-1);        // fails at 0,1,2; first kept: R8
    s0_m = '0;
    br_a = 5; br_b = 4; run(2);   // extra start ignored: R9
    br_a = -1; br_b = -1;
    run(1);                       // clean with extra start: R9 R7

    for (int b = 0; b < W; b++) begin  // R10 stuck bits
      s0_m = W'(1) << b; run(-1); check(!pass, "R10 stuck0", 32'(pass), 0);
      s0_m = '0;
      s1_m = W'(1) << b; run(-1); check(!pass, "R10 stuck1", 32'(pass), 0);
      s1_m = '0;
    end
    for (int a = 0; a < W; a++)        // R10 shorted pairs
      for (int b = a + 1; b < W; b++) begin
        br_a = a; br_b = b; run(-1);
        check(!pass, "R10 bridge", 32'(pass), 0);
      end
    br_a = -1; br_b = -1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule